// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches one tearing-effect line coming back from an external display panel. Vertical and horizontal sync share that pin, so the block measures how long each pulse stays at its active level, counting only cycles in which a divided tick enable is high. A long pulse is a frame (vertical) sync. A pulse that is shorter but still long enough is a line (horizontal) sync. Anything shorter is noise and is dropped. Each sync type has its own polarity-inversion control.

After every vertical sync the block counts line syncs. It can raise its match interrupt on every vertical sync, or once per frame when the line count reaches a programmed target. The interrupt is an active-low, one-cycle strobe, and its falling edge tells the transfer engine that a frame write may begin. The tearing input is taken to be already synchronous to `clk`.

Top module: `te_sync_detect`

## Requirements
- R1: After reset, `irq_n` is high and no match is pending; the line count is zero and the line match is disarmed.
- R2: A run at the vertical active level (`te_in ^ vs_inv` high) that lasts at least `(vs_code+1)*8` ticks is classified as vertical sync when it ends. It clears the line count to zero and arms the line match.
- R3: A run at the horizontal active level (`te_in ^ hs_inv` high) with a tick count from `hs_code+1` up to one below the vertical threshold is classified as horizontal sync when it ends. It increments the line count, which saturates at 2047.
- R4: An active run shorter than `hs_code+1` ticks is ignored and leaves the line count unchanged.
- R5: Setting `hs_inv` and `vs_inv` makes the low level of `te_in` the active level for the respective sync type.
- R6: With `mode` = 3 (vertical only), every vertical sync produces exactly one match.
- R7: With `mode` = 2 (line), a match occurs when a classified sync brings the line count to `target_line` while the match is armed, or when a vertical sync itself gives a count equal to the target. After a match, no further match occurs until the next vertical sync.
- R8: When `te_enable` is low or `mode` is 0 or 1, no match is produced, and the line count and armed state are cleared.
- R9: A match drives `irq_n` low for exactly one cycle. The cycle that ends a run decides the match, and `irq_n` falls on the following clock edge.
- R10: Cycles with `tick_en` low do not add to a pulse's measured length.
- R11: If `te_enable` drops in the same cycle in which a run ends, the disable wins and no match is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Divided measurement tick enable |
| te_in | input | 1 | Tearing-effect line from the panel (synchronous) |
| te_enable | input | 1 | Enable for the tearing logic |
| mode | input | 2 | 0/1 off, 2 line match, 3 vertical-only match |
| hs_inv | input | 1 | Horizontal sync active low when set |
| vs_inv | input | 1 | Vertical sync active low when set |
| hs_code | input | 3 | Horizontal threshold in ticks, minus one |
| vs_code | input | 9 | Vertical threshold in units of 8 ticks, minus one |
| target_line | input | 11 | Line number that triggers a match in mode 2 |
| irq_n | output | 1 | Active-low one-cycle match strobe |

## Verification
The case that needs care is a run ending in the same cycle in which the tearing enable is withdrawn. In that cycle, both classifying the run and clearing the line state want the same registers. The bench provokes this by lowering `te_enable` on the same clock as the end of a vertical pulse that would otherwise match. It expects no strobe and a cleared line count, and it confirms the cleared count on the next frame, where a line match must need a fresh vertical sync. Random pulse lengths and random tick gating, in both polarities and both match modes, are checked against a bench model of the classification rules. Directed pulses sit one tick on either side of each threshold.

// File: rtl/te_sync_detect.sv
module te_sync_detect #(
  parameter int HS_CODE_W = 3,
  parameter int VS_CODE_W = 9,
  parameter int LINE_W    = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 te_in,
  input  logic                 te_enable,
  input  logic [1:0]           mode,
  input  logic                 hs_inv,
  input  logic                 vs_inv,
  input  logic [HS_CODE_W-1:0] hs_code,
  input  logic [VS_CODE_W-1:0] vs_code,
  input  logic [LINE_W-1:0]    target_line,
  output logic                 irq_n
);

  localparam int CNT_W = VS_CODE_W + 4;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [CNT_W-1:0]  vs_cnt, hs_cnt;
  logic [LINE_W-1:0] line_cnt, line_next;
  logic              act_v_d, act_h_d, armed, match_q;

  wire act_v  = te_in ^ vs_inv;
  wire act_h  = te_in ^ hs_inv;
  wire run_en = te_enable & mode[1];

  wire [CNT_W-1:0] vs_ticks = (CNT_W'(vs_code) + CNT_W'(1)) << 3;
  wire [CNT_W-1:0] hs_ticks = CNT_W'(hs_code) + CNT_W'(1);

  wire vs_det = run_en & act_v_d & ~act_v & (vs_cnt >= vs_ticks);
  wire hs_det = run_en & act_h_d & ~act_h & (hs_cnt >= hs_ticks) & (hs_cnt < vs_ticks);

  assign line_next = vs_det ? '0 : (line_cnt == LINE_MAX ? line_cnt : line_cnt + 1'b1);

  wire hit = mode[0] ? vs_det
                     : ((vs_det | hs_det) & (vs_det | armed) & (line_next == target_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_v_d <= 1'b0;
      act_h_d <= 1'b0;
      vs_cnt  <= '0;
      hs_cnt  <= '0;
    end else begin
      act_v_d <= act_v;
      act_h_d <= act_h;
      if (!act_v)                         vs_cnt <= '0;
      else if (tick_en && vs_cnt != CNT_MAX) vs_cnt <= vs_cnt + 1'b1;
      if (!act_h)                         hs_cnt <= '0;
      else if (tick_en && hs_cnt != CNT_MAX) hs_cnt <= hs_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      armed    <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      match_q <= hit;
      if (!run_en) begin
        line_cnt <= '0;
        armed    <= 1'b0;
      end else begin
        if (vs_det || hs_det) line_cnt <= line_next;
        if (hit)              armed <= 1'b0;
        else if (vs_det)      armed <= 1'b1;
      end
    end
  end

  assign irq_n = ~match_q;

  assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> irq_n);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (irq_n && line_cnt == '0 && !armed));

  assert_vs_clears_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_det |=> (line_cnt == '0));

  assert_hs_steps_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_det && line_cnt != LINE_MAX) |=> (line_cnt == $past(line_cnt) + 1'b1));

  assert_once_per_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode[0]) |=> !armed);

  assert_tick_gating_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && !tick_en) |=> $stable(vs_cnt));

endmodule

// File: tb/te_sync_detect_tb.sv
`timescale 1ns/1ps
module te_sync_detect_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, te_in = 1'b0, te_enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic hs_inv = 1'b0, vs_inv = 1'b0;
  logic [2:0] hs_code = 3'd0;
  logic [8:0] vs_code = 9'd0;
  logic [10:0] target_line = 11'd0;
  logic irq_n;

  te_sync_detect u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .te_in(te_in),
    .te_enable(te_enable), .mode(mode), .hs_inv(hs_inv), .vs_inv(vs_inv),
    .hs_code(hs_code), .vs_code(vs_code), .target_line(target_line), .irq_n(irq_n));

  always #5 clk = ~clk;

  int vecs = 0, errs = 0, lows = 0;
  int exp_line = 0;
  bit exp_armed = 0, prev_low = 0, inv = 0, finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle(input bit act, input bit tk);
    @(negedge clk);
    if (!irq_n) lows++;
    if (!irq_n && prev_low) check(0, "R9 strobe width", 2, 1);
    prev_low = !irq_n;
    te_in   = act ^ inv;
    tick_en = tk;
  endtask

  task automatic model_clear();
    exp_line = 0; exp_armed = 0;
  endtask

  function automatic int classify(input int ticks);
    int hs_t = int'(hs_code) + 1;
    int vs_t = (int'(vs_code) + 1) * 8;
    if (ticks >= vs_t) return 2;
    if (ticks >= hs_t) return 1;
    return 0;
  endfunction

  task automatic model_step(input int ticks, input bit en, output int exp_m);
    int cls = classify(ticks);
    int nxt;
    bit hit;
    exp_m = 0;
    if (!en) begin model_clear(); return; end
    if (cls == 0) return;
    nxt = (cls == 2) ? 0 : (exp_line == 2047 ? 2047 : exp_line + 1);
    hit = mode[0] ? (cls == 2) : ((nxt == int'(target_line)) && (cls == 2 || exp_armed));
    exp_line = nxt;
    if (hit) exp_armed = 0; else if (cls == 2) exp_armed = 1;
    exp_m = hit ? 1 : 0;
  endtask

  task automatic pulse(input int len, input int tick_pct, input bit drop_en, input string req);
    int ticks = 0;
    int exp_m;
    bit en;
    lows = 0;
    for (int i = 0; i < len; i++) begin
      bit tk = ($urandom % 100) < tick_pct;
      ticks += tk;
      cycle(1'b1, tk);
    end
    cycle(1'b0, 1'b1);
    if (drop_en) te_enable = 1'b0;
    en = te_enable && mode[1];
    for (int i = 0; i < 4; i++) cycle(1'b0, ($urandom % 2) == 1);
    model_step(ticks, en, exp_m);
    check(lows == exp_m, req, lows, exp_m);
  endtask

  task automatic exact(input int ticks, input string req);
    pulse(ticks, 100, 1'b0, req);
  endtask

  task automatic random_run(input int n, input bit m3);
    for (int k = 0; k < n; k++) begin
      int vs_t = (int'(vs_code) + 1) * 8;
      int len = ($urandom % 4 == 0) ? vs_t + 1 + int'($urandom % vs_t) : 1 + int'($urandom % vs_t);
      if (m3) pulse(len, 75, 1'b0, "R6/R2/R10 random");
      else    pulse(len, 75, 1'b0, "R7/R3/R4 random");
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(irq_n === 1'b1, "R1 reset irq_n", int'(irq_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(irq_n === 1'b1, "R1 after reset", int'(irq_n), 1);

    hs_code = 3'd2; vs_code = 9'd1;
    mode = 2'd3; te_enable = 1'b0; model_clear();
    exact(20, "R8 enable low");
    mode = 2'd0; te_enable = 1'b1;
    exact(20, "R8 mode 0");
    mode = 2'd1;
    exact(20, "R8 mode 1");

    mode = 2'd3;
    exact(16, "R2 vs at threshold");
    exact(15, "R6 hs no match in vs-only");
    pulse(40, 0, 1'b0, "R10 no ticks");
    pulse(30, 50, 1'b0, "R10 half ticks");
    exact(16, "R11 setup vs");
    pulse(16, 100, 1'b1, "R11 disable in end cycle");
    te_enable = 1'b1;

    mode = 2'd2; target_line = 11'd1;
    exact(2, "R4 below hs threshold");
    exact(16, "R7 vs arms");
    exact(2, "R4 short pulse ignored");
    exact(3, "R3 hs at threshold matches line 1");
    exact(15, "R7 suppressed until vs");
    exact(16, "R7 rearm");
    exact(15, "R3 hs just below vs threshold");

    target_line = 11'd2;
    exact(16, "R7 frame");
    exact(3, "R7 line1");
    te_enable = 1'b0; model_clear();
    cycle(1'b0, 1'b1);
    te_enable = 1'b1;
    exact(3, "R11 line cleared, no arm");
    exact(3, "R11 still unarmed");

    target_line = 11'd0;
    exact(16, "R7 target zero at vs");
    exact(3, "R7 target zero no repeat");

    inv = 1'b1; hs_inv = 1'b1; vs_inv = 1'b1;
    cycle(1'b0, 1'b0); cycle(1'b0, 1'b0);
    mode = 2'd3; target_line = 11'd3;
    exact(16, "R5 inverted vs");
    exact(15, "R5 inverted short");
    hs_code = 3'd4; vs_code = 9'd3;
    random_run(120, 1'b1);
    mode = 2'd2; model_clear(); te_enable = 1'b0; cycle(1'b0, 1'b0); te_enable = 1'b1;
    random_run(150, 1'b0);

    inv = 1'b0; hs_inv = 1'b0; vs_inv = 1'b0;
    cycle(1'b0, 1'b0); cycle(1'b0, 1'b0);
    hs_code = 3'd7; vs_code = 9'd2; target_line = 11'd2;
    random_run(150, 1'b0);
    mode = 2'd3;
    random_run(100, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule